// File: doc/BRIEF.md
# Receiver Eye-Scan Sweep Controller

This block is the digital side of a receiver eye monitor. A second "roaming" sampler sits beside the main data sampler. Its phase and amplitude offsets come from two code outputs of this block. The controller walks those codes over a two-dimensional grid. At every grid point it waits for the analog offsets to settle. It then compares the roaming decision with the main decision over a programmed number of received bits and counts the disagreements. No special traffic pattern is needed, because ordinary received data serves as its own reference.

Each point's error count goes into a result memory. Software reads that memory through a simple synchronous read port once the sweep has finished. Software programs the grid shape, the step sizes, the amplitude limit, the bits per point and the settle time, then issues a start pulse. It watches `busy` and `done`, and may abort at any time.

The bit stream has a valid strobe and no ready signal. A receiver cannot be back-pressured, so beats that arrive outside a counting window are dropped rather than stalled. Control and status pins are plain levels or pulses.

Top module: `eye_scan_ctrl`

## Requirements
- R1: A sweep visits all `cfg_nx`×`cfg_ny` points. Amplitude is the outer loop and phase is the inner loop. At phase index i and amplitude index j, `x_code` = i·`cfg_x_step` and `y_code` = j·`cfg_y_step` − `cfg_y_lim`, in two's complement, so amplitude runs from the negative limit upward.
- R2: The result of point (i, j) is stored at address j·`cfg_nx` + i. `rd_data` shows the word at `rd_addr` one clock after that address is presented.
- R3: Each time the offset codes change, `cfg_settle`+1 cycles pass before counting starts. Beats arriving in that window are not counted.
- R4: A beat is counted only in a cycle with `in_valid` high. It is an error when `in_data` differs from `in_roam`. A point ends after `cfg_bits` counted beats, and `cfg_bits` must be at least 1.
- R5: An error count saturates at 2^CNT_W − 1 and does not wrap.
- R6: A `start` pulse while `busy` is high is ignored, and the sweep goes on at its current point.
- R7: `abort` returns the controller to idle on the next clock, with `busy` low and `done` low.
- R8: After reset, `busy` and `done` are low. `busy` rises on the clock that samples `start` and falls when the last point is stored. At that same point `done` rises, and it stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nx | input | NXW | Number of phase points (1..MAX_NX) |
| cfg_ny | input | NYW | Number of amplitude points (1..MAX_NY) |
| cfg_x_step | input | X_W | Phase step |
| cfg_y_step | input | Y_W | Amplitude step |
| cfg_y_lim | input | Y_W | Magnitude of the first (most negative) amplitude code |
| cfg_bits | input | BIT_W | Counted beats per point |
| cfg_settle | input | 8 | Settle cycles minus one |
| start | input | 1 | Start pulse |
| abort | input | 1 | Abort level or pulse |
| in_valid | input | 1 | Beat strobe |
| in_data | input | 1 | Main sampler decision |
| in_roam | input | 1 | Roaming sampler decision |
| x_code | output | X_W | Phase offset code |
| y_code | output | Y_W | Signed amplitude offset code |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Last sweep completed |
| rd_addr | input | AW | Result read address |
| rd_data | output | CNT_W | Result read data (one-cycle latency) |

## Verification
The bench builds the block with MAX_NX = MAX_NY = 4 and CNT_W = 6. With these values a full 4×4 grid fills every memory word, so a wrong address mapping corrupts a neighbour's result. The narrow counter saturates at 63 after only a hundred beats, which keeps the saturation case short. The bench picks the expected error pattern from the offset codes it sees at the pins. Some points match on every beat, some mismatch on every beat and some mismatch on alternate beats. Invalid beats always carry a mismatch, so any code, address or gating error shows up as a wrong count.

// File: rtl/eye_scan_pkg.sv
package eye_scan_pkg;
  localparam int SETTLE_W = 8;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_COUNT  = 2'd2,
    ST_STORE  = 2'd3
  } scan_st_t;
endpackage

// File: rtl/eye_scan_seq.sv
module eye_scan_seq
  import eye_scan_pkg::*;
#(
  parameter int XIW = 3,
  parameter int YIW = 3,
  parameter int NXW = 4,
  parameter int NYW = 4,
  parameter int AW  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NXW-1:0]      cfg_nx,
  input  logic [NYW-1:0]      cfg_ny,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic                start,
  input  logic                abort,
  input  logic                meas_done,
  output logic [XIW-1:0]      x_idx,
  output logic [YIW-1:0]      y_idx,
  output scan_st_t            st,
  output logic                clr,
  output logic                wr_en,
  output logic [AW-1:0]       wr_addr,
  output logic                busy,
  output logic                done
);
  scan_st_t            st_q;
  logic [SETTLE_W-1:0] scnt_q;
  logic [XIW-1:0]      xi_q;
  logic [YIW-1:0]      yi_q;
  logic                done_q;
  logic                last_x, last_y;

  assign last_x  = (int'(xi_q) + 1) >= int'(cfg_nx);
  assign last_y  = (int'(yi_q) + 1) >= int'(cfg_ny);
  assign clr     = (st_q == ST_SETTLE) && (scnt_q == '0);
  assign wr_en   = (st_q == ST_STORE);
  assign wr_addr = AW'(yi_q) * AW'(cfg_nx) + AW'(xi_q);
  assign x_idx   = xi_q;
  assign y_idx   = yi_q;
  assign st      = st_q;
  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      scnt_q <= '0;
      xi_q   <= '0;
      yi_q   <= '0;
      done_q <= 1'b0;
    end else if (abort) begin
      st_q <= ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          xi_q   <= '0;
          yi_q   <= '0;
          scnt_q <= cfg_settle;
          done_q <= 1'b0;
          st_q   <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (scnt_q == '0) st_q <= ST_COUNT;
          else              scnt_q <= scnt_q - 1'b1;
        end
        ST_COUNT: if (meas_done) st_q <= ST_STORE;
        default: begin
          scnt_q <= cfg_settle;
          if (last_x) begin
            xi_q <= '0;
            if (last_y) begin
              yi_q   <= '0;
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              yi_q <= yi_q + 1'b1;
              st_q <= ST_SETTLE;
            end
          end else begin
            xi_q <= xi_q + 1'b1;
            st_q <= ST_SETTLE;
          end
        end
      endcase
    end
  end

  // R1: indices stay inside the programmed grid while sweeping
  p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (xi_q < cfg_nx) && (yi_q < cfg_ny));
  // R6: start during a measurement leaves the point untouched
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COUNT && start && !abort && !meas_done)
      |=> (st_q == ST_COUNT) && $stable(xi_q) && $stable(yi_q));
  // R7: abort while busy drops to idle with done low
  p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && busy) |=> !busy && !done_q);
  // R8: done only rises out of the store of the last point
  p_done_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(st_q) == ST_STORE) && !busy);
endmodule

// File: rtl/eye_scan_errcnt.sv
module eye_scan_errcnt #(
  parameter int BIT_W = 16,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             in_valid,
  input  logic             in_data,
  input  logic             in_roam,
  input  logic [BIT_W-1:0] cfg_bits,
  output logic [CNT_W-1:0] err,
  output logic             meas_done
);
  logic [BIT_W-1:0] bits_q;
  logic [CNT_W-1:0] err_q, err_nx;
  logic [BIT_W:0]   bits_nx;
  logic             beat, mism;

  assign beat      = en && in_valid;
  assign mism      = in_data ^ in_roam;
  assign bits_nx   = {1'b0, bits_q} + 1'b1;
  assign meas_done = beat && (bits_nx >= {1'b0, cfg_bits});
  assign err       = err_q;

  generate
    if (CNT_W > BIT_W) begin : g_plain
      assign err_nx = err_q + CNT_W'(mism);
    end else begin : g_sat
      assign err_nx = (mism && (err_q != {CNT_W{1'b1}})) ? err_q + 1'b1 : err_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      err_q  <= '0;
    end else if (clr) begin
      bits_q <= '0;
      err_q  <= '0;
    end else if (beat) begin
      bits_q <= bits_nx[BIT_W-1:0];
      err_q  <= err_nx;
    end
  end

  // R5: a saturated count holds until cleared
  p_err_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q == {CNT_W{1'b1}} && !clr) |=> err_q == {CNT_W{1'b1}});
  // R4: errors never outnumber counted beats
  p_err_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_q <= bits_q);
  // R4: outside a counting window nothing is counted
  p_no_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(bits_q) && $stable(err_q));
endmodule

// File: rtl/eye_scan_resmem.sv
module eye_scan_resmem #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int DW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
    rd_q <= mem_q[rd_addr];
  end
  assign rd_data = rd_q;

  // R2: every stored point lands inside the memory
  p_wr_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> int'(wr_addr) < DEPTH);
endmodule

// File: rtl/eye_scan_ctrl.sv
module eye_scan_ctrl
  import eye_scan_pkg::*;
#(
  parameter int X_W    = 8,
  parameter int Y_W    = 9,
  parameter int BIT_W  = 16,
  parameter int CNT_W  = 12,
  parameter int MAX_NX = 8,
  parameter int MAX_NY = 8,
  localparam int NXW   = $clog2(MAX_NX + 1),
  localparam int NYW   = $clog2(MAX_NY + 1),
  localparam int DEPTH = MAX_NX * MAX_NY,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NXW-1:0]        cfg_nx,
  input  logic [NYW-1:0]        cfg_ny,
  input  logic [X_W-1:0]        cfg_x_step,
  input  logic [Y_W-1:0]        cfg_y_step,
  input  logic [Y_W-1:0]        cfg_y_lim,
  input  logic [BIT_W-1:0]      cfg_bits,
  input  logic [SETTLE_W-1:0]   cfg_settle,
  input  logic                  start,
  input  logic                  abort,
  input  logic                  in_valid,
  input  logic                  in_data,
  input  logic                  in_roam,
  output logic [X_W-1:0]        x_code,
  output logic signed [Y_W-1:0] y_code,
  output logic                  busy,
  output logic                  done,
  input  logic [AW-1:0]         rd_addr,
  output logic [CNT_W-1:0]      rd_data
);
  localparam int XIW = (MAX_NX > 1) ? $clog2(MAX_NX) : 1;
  localparam int YIW = (MAX_NY > 1) ? $clog2(MAX_NY) : 1;

  logic [XIW-1:0]   x_idx;
  logic [YIW-1:0]   y_idx;
  scan_st_t         st;
  logic             clr, wr_en, meas_done;
  logic [AW-1:0]    wr_addr;
  logic [CNT_W-1:0] err;

  eye_scan_seq #(.XIW(XIW), .YIW(YIW), .NXW(NXW), .NYW(NYW), .AW(AW)) u_seq (
    .clk, .rst_n, .cfg_nx, .cfg_ny, .cfg_settle, .start, .abort, .meas_done,
    .x_idx, .y_idx, .st, .clr, .wr_en, .wr_addr, .busy, .done);

  eye_scan_errcnt #(.BIT_W(BIT_W), .CNT_W(CNT_W)) u_cnt (
    .clk, .rst_n, .clr, .en(st == ST_COUNT), .in_valid, .in_data, .in_roam,
    .cfg_bits, .err, .meas_done);

  eye_scan_resmem #(.DEPTH(DEPTH), .AW(AW), .DW(CNT_W)) u_mem (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data(err), .rd_addr, .rd_data);

  assign x_code = X_W'(x_idx) * cfg_x_step;
  assign y_code = Y_W'(y_idx) * cfg_y_step - cfg_y_lim;

  // R3: offsets are held steady for the whole counting window
  p_code_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_COUNT && !abort) |=> $stable(x_code) && $stable(y_code));
endmodule

// File: tb/eye_scan_ctrl_bench.sv
module eye_scan_ctrl_bench;
  localparam int X_W = 8, Y_W = 9, BIT_W = 16, CNT_W = 6, MX = 4, MY = 4;
  localparam int SAT = (1 << CNT_W) - 1;
  localparam int NV = 3;
  // nx, ny, x_step, y_step, y_lim, bits, settle
  localparam int VEC [NV][7] = '{
    '{4, 4, 5, 3, 4, 10, 0},
    '{3, 2, 16, 8, 4, 40, 3},
    '{1, 3, 1, 1, 1, 2, 1}
  };

  logic clk = 0, rst_n = 0;
  logic [2:0] cfg_nx = 1;
  logic [2:0] cfg_ny = 1;
  logic [X_W-1:0] cfg_x_step = 0;
  logic [Y_W-1:0] cfg_y_step = 0, cfg_y_lim = 0;
  logic [BIT_W-1:0] cfg_bits = 1;
  logic [7:0] cfg_settle = 0;
  logic start = 0, abort = 0, in_valid = 0, in_data = 0, in_roam = 0;
  logic [X_W-1:0] x_code;
  logic signed [Y_W-1:0] y_code;
  logic busy, done;
  logic [3:0] rd_addr = 0;
  logic [CNT_W-1:0] rd_data;

  int tests = 0, fails = 0;
  int drv_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic tog = 0;

  always #2 clk = ~clk;

  eye_scan_ctrl #(.X_W(X_W), .Y_W(Y_W), .BIT_W(BIT_W), .CNT_W(CNT_W),
                  .MAX_NX(MX), .MAX_NY(MY)) u_eye_scan_ctrl (
    .clk, .rst_n, .cfg_nx, .cfg_ny, .cfg_x_step, .cfg_y_step, .cfg_y_lim,
    .cfg_bits, .cfg_settle, .start, .abort, .in_valid, .in_data, .in_roam,
    .x_code, .y_code, .busy, .done, .rd_addr, .rd_data);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mode_of(input int x, input int y);
    return (((x + 2 * y) % 3) + 3) % 3;
  endfunction

  // beat driver: 0 = pattern from codes, 1 = all mismatch, 2 = all match
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    in_data = lfsr[2];
    if (drv_mode == 1) begin
      in_valid = 1; in_roam = ~in_data;
    end else if (drv_mode == 2) begin
      in_valid = 1; in_roam = in_data;
    end else begin
      in_valid = lfsr[0] | lfsr[1];
      if (!in_valid) in_roam = ~in_data;
      else begin
        case (mode_of(int'(x_code), int'(y_code)))
          0: in_roam = in_data;
          1: in_roam = ~in_data;
          default: in_roam = in_data ^ tog;
        endcase
        tog = ~tog;
      end
    end
  end

  task automatic setup(input int v[7]);
    cfg_nx = 3'(v[0]); cfg_ny = 3'(v[1]); cfg_x_step = X_W'(v[2]);
    cfg_y_step = Y_W'(v[3]); cfg_y_lim = Y_W'(v[4]);
    cfg_bits = BIT_W'(v[5]); cfg_settle = 8'(v[6]);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done === 1'b1, "R8 done after sweep", int'(done), 1);
    chk(busy === 1'b0, "R8 busy low after sweep", int'(busy), 0);
  endtask

  task automatic readback(input int v[7]);
    for (int j = 0; j < v[1]; j++)
      for (int i = 0; i < v[0]; i++) begin
        int x, y, m, e;
        x = (i * v[2]) % (1 << X_W);
        y = j * v[3] - v[4];
        m = mode_of(x, y);
        e = (m == 0) ? 0 : (m == 1) ? v[5] : v[5] / 2;
        if (e > SAT) e = SAT;
        rd_addr = 4'(j * v[0] + i);
        @(negedge clk);
        chk(int'(rd_data) == e, "R1/R2/R4 point result", int'(rd_data), e);
      end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0, "R8 reset busy", int'(busy), 0);
    chk(done === 1'b0, "R8 reset done", int'(done), 0);

    // table-driven sweeps
    for (int k = 0; k < NV; k++) begin
      drv_mode = 0;
      setup(VEC[k]);
      pulse_start();
      chk(busy === 1'b1, "R8 busy after start", int'(busy), 1);
      chk(done === 1'b0, "R8 done cleared by start", int'(done), 0);
      chk(int'(x_code) == 0, "R1 first x code", int'(x_code), 0);
      chk(int'(y_code) == -VEC[k][4], "R1 first y code", int'(y_code), -VEC[k][4]);
      wait_done();
      readback(VEC[k]);
    end

    // R6: start while busy is ignored
    setup(VEC[0]);
    pulse_start();
    while (int'(y_code) == -VEC[0][4]) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    chk(int'(y_code) != -VEC[0][4], "R6 start ignored while busy", int'(y_code), -VEC[0][4] + VEC[0][3]);
    chk(busy === 1'b1, "R6 still busy", int'(busy), 1);
    wait_done();
    readback(VEC[0]);

    // R7: abort
    pulse_start();
    repeat (30) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    chk(busy === 1'b0, "R7 busy low after abort", int'(busy), 0);
    chk(done === 1'b0, "R7 done low after abort", int'(done), 0);
    repeat (50) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R7 stays idle", int'({busy, done}), 0);

    // R3: beats during settle are ignored
    setup('{1, 1, 0, 0, 0, 4, 20});
    drv_mode = 1;
    pulse_start();
    repeat (8) @(negedge clk);
    drv_mode = 2;
    wait_done();
    rd_addr = 0; @(negedge clk);
    chk(int'(rd_data) == 0, "R3 settle window not counted", int'(rd_data), 0);

    // R5: saturation
    setup('{1, 1, 0, 0, 0, 100, 0});
    drv_mode = 1;
    pulse_start();
    wait_done();
    rd_addr = 0; @(negedge clk);
    chk(int'(rd_data) == SAT, "R5 count saturates", int'(rd_data), SAT);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule